// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the host-facing register layer of a two-channel serial communications controller. A byte-oriented bus reaches each channel through two ports: a command port and a data port. Most registers are not directly addressed. Software first writes a register number to the command port and then either writes the value or reads the selected register back through the same port. Each channel holds sixteen write registers and presents sixteen read registers. Read registers report live status, mirror the baud time constants, or hold the shared interrupt-pending bits.

The data port sends a byte out on the channel's transmit output. When local loopback is enabled, the same byte is also queued into that channel's receive FIFO. A data-port read pops the oldest received byte. A single pending register, visible only through channel A, collects receive and transmit events from both channels. Together with a master enable, it drives one interrupt line.

The bus carries 16 bits. This lets the block accept a legacy access form in which the byte sits in the upper half of the word.

Top module: `dual_sio_regif`

## Requirements
- R1: `bus_addr[3]` selects the channel (0 = A, 1 = B). Offset `bus_addr[2:0]` = 1 is the command port and offset 5 is the data port. At any other offset not covered by R12, a write changes nothing (the pointer and its selection are kept) and a read returns 0.
- R2: A command-port write with no selection pending latches `wdata[3:0]` as the register pointer. The next command-port write stores the byte into the selected write register, then returns the pointer to 0 with no selection pending.
- R3: A command-port read returns the read register that the pointer selects. It then returns the pointer to 0 and clears any pending selection. A read with no pointer written therefore returns read register 0.
- R4: Read register 0 equals 0x04 (bit 2, transmit empty, always set) ORed with bit 0, which is set while the channel's receive FIFO is non-empty. Read register 1 and every read register not named in R5, R6 or R11 read 0x00.
- R5: Read registers 12 and 13 return the last values written to the same channel's write registers 12 and 13.
- R6: Interrupt enabling is taken from channel A only: write register 9 bit 3 is the master enable, and write register 1 bits [4:3] non-zero enable receive interrupts. While both are enabled, a non-empty receive FIFO sets pending bit 5 (channel A) or bit 2 (channel B) on the next clock.
- R7: A data-port write while the master enable is set and the writing channel's write register 1 bit 1 is set sets pending bit 4 (channel A) or bit 1 (channel B).
- R8: A data-port write drives `tx_valid[ch]` high for one cycle on the next clock, with the byte on `tx_data[ch*8 +: 8]`.
- R9: When the channel's write register 14 bit 4 is set, a transmitted byte is also pushed into that channel's receive FIFO.
- R10: A data-port read returns the FIFO head byte and pops it. An empty FIFO returns 0x00 and pops nothing. Every data-port read clears all pending bits.
- R11: The pending bits read as read register 3 of channel A, and that command-port read clears them. Read register 3 of channel B reads 0x00 and leaves the pending bits unchanged.
- R12: An access at offset 0 or 4 that is a read, or a write with `wdata[7:0]` = 0, is handled as an access to offset 1 or 5 with the byte taken from `wdata[15:8]`. Read data for such an access is returned in `rdata[15:8]`.
- R13: `irq` is high exactly while the master enable is set and at least one pending bit is set.
- R14: Each receive FIFO holds RX_DEPTH bytes in arrival order. A push into a full FIFO is dropped. A line byte arriving in the same cycle as a loopback byte takes the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Channel in bit 3, port offset in bits [2:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| rx_in_valid | input | 2 | Per-channel received-byte strobe |
| rx_in_data | input | 16 | Received bytes, channel c in bits [c*8+7:c*8] |
| tx_valid | output | 2 | Per-channel transmit strobe |
| tx_data | output | 16 | Transmitted bytes, channel c in bits [c*8+7:c*8] |
| irq | output | 1 | Interrupt request |

## Verification
If the register pointer or its selection flag is corrupted, the effect appears on the very next command-port access. A value lands in the wrong write register, or a read returns the wrong register; this shows either in the same read or in a later read-back of registers 12 and 13. Pending-bit faults reach `irq` and the channel A read of register 3 within one clock of the setting event. Clear faults show up as `irq` staying high after a read. A FIFO ordering or full-drop fault shows up as a wrong byte on a later data-port read, or as a wrong bit 0 in read register 0.

// File: rtl/sio_regif_pkg.sv
package sio_regif_pkg;

    localparam int NUM_CH   = 2;
    localparam int NUM_REGS = 16;

    // register numbers
    localparam logic [3:0] REG_STATUS  = 4'd0;
    localparam logic [3:0] REG_IRQCFG  = 4'd1;
    localparam logic [3:0] REG_PENDING = 4'd3;
    localparam logic [3:0] REG_MASTER  = 4'd9;
    localparam logic [3:0] REG_TC_LO   = 4'd12;
    localparam logic [3:0] REG_TC_HI   = 4'd13;
    localparam logic [3:0] REG_MISC    = 4'd14;

    // bit positions
    localparam int BIT_TXIE  = 1;
    localparam int BIT_MIE   = 3;
    localparam int BIT_LOOP  = 4;

    typedef struct packed {
        logic [NUM_CH-1:0][NUM_REGS-1:0][7:0] wfile;
        logic [NUM_CH-1:0][3:0]               ptr;
        logic [NUM_CH-1:0]                    sel;
        logic [7:0]                           pend;
        logic [NUM_CH-1:0]                    tx_vld;
        logic [NUM_CH-1:0][7:0]               tx_byte;
    } regif_state_t;

    function automatic int rx_pend_pos(input int ch);
        return (ch == 0) ? 5 : 2;
    endfunction

    function automatic int tx_pend_pos(input int ch);
        return (ch == 0) ? 4 : 1;
    endfunction

endpackage

// File: rtl/sio_bus_decode.sv
module sio_bus_decode (
    input  logic        valid,
    input  logic        write,
    input  logic [3:0]  addr,
    input  logic [15:0] wdata,
    output logic        ch,
    output logic        cmd_wr,
    output logic        cmd_rd,
    output logic        dat_wr,
    output logic        dat_rd,
    output logic        upper,
    output logic [7:0]  wbyte
);
    logic [2:0] off;
    logic [2:0] eff;

    always_comb begin
        off   = addr[2:0];
        upper = ((off == 3'd0) || (off == 3'd4)) && (!write || (wdata[7:0] == 8'h00));
        eff   = upper ? (off + 3'd1) : off;
        wbyte = upper ? wdata[15:8] : wdata[7:0];
        ch    = addr[3];
        cmd_wr = valid &&  write && (eff == 3'd1);
        cmd_rd = valid && !write && (eff == 3'd1);
        dat_wr = valid &&  write && (eff == 3'd5);
        dat_rd = valid && !write && (eff == 3'd5);
    end
endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_d, wp_q, rp_d, rp_q;
    logic [CW-1:0]    cnt_d, cnt_q;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        do_pop  = pop && (cnt_q != '0);
        do_push = push && (cnt_q != CW'(DEPTH));
        wp_d  = do_push ? bump(wp_q) : wp_q;
        rp_d  = do_pop  ? bump(rp_q) : rp_q;
        cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end

    assign head  = mem[rp_q];
    assign count = cnt_q;

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R14
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && cnt_q == CW'(DEPTH)) |=> (cnt_q == CW'(DEPTH))); // R14
endmodule

// File: rtl/dual_sio_regif.sv
module dual_sio_regif
    import sio_regif_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    localparam int CW = $clog2(RX_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic [1:0]  rx_in_valid,
    input  logic [15:0] rx_in_data,
    output logic [1:0]  tx_valid,
    output logic [15:0] tx_data,
    output logic        irq
);
    regif_state_t st_d, st_q;

    logic       dec_ch, dec_cmd_wr, dec_cmd_rd, dec_dat_wr, dec_dat_rd, dec_upper;
    logic [7:0] dec_wbyte;

    logic [NUM_CH-1:0]         f_push, f_pop, f_avail;
    logic [NUM_CH-1:0][7:0]    f_pdata, f_head;
    logic [NUM_CH-1:0][CW-1:0] f_cnt;

    logic       mie, rx_mode, pend_clr;
    logic [7:0] pend_set, rbyte;

    sio_bus_decode u_dec (
        .valid (bus_valid), .write (bus_write), .addr (bus_addr), .wdata (bus_wdata),
        .ch (dec_ch), .cmd_wr (dec_cmd_wr), .cmd_rd (dec_cmd_rd),
        .dat_wr (dec_dat_wr), .dat_rd (dec_dat_rd), .upper (dec_upper), .wbyte (dec_wbyte)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            f_avail[c] = (f_cnt[c] != '0);
            f_push[c]  = rx_in_valid[c] ||
                         (dec_dat_wr && (dec_ch == 1'(c)) && st_q.wfile[c][REG_MISC][BIT_LOOP]);
            f_pdata[c] = rx_in_valid[c] ? rx_in_data[c*8 +: 8] : dec_wbyte;
            f_pop[c]   = dec_dat_rd && (dec_ch == 1'(c));
        end

        sio_rx_fifo #(.DEPTH (RX_DEPTH), .WIDTH (8)) u_fifo (
            .clk (clk), .rst_n (rst_n),
            .push (f_push[c]), .push_data (f_pdata[c]),
            .pop (f_pop[c]), .head (f_head[c]), .count (f_cnt[c])
        );

        assign tx_valid[c]        = st_q.tx_vld[c];
        assign tx_data[c*8 +: 8]  = st_q.tx_byte[c];
    end

    // read register mux for the addressed channel
    always_comb begin
        unique case (st_q.ptr[dec_ch])
            REG_STATUS:  rbyte = 8'h04 | {7'd0, f_avail[dec_ch]};
            REG_PENDING: rbyte = (dec_ch == 1'b0) ? st_q.pend : 8'h00;
            REG_TC_LO:   rbyte = st_q.wfile[dec_ch][REG_TC_LO];
            REG_TC_HI:   rbyte = st_q.wfile[dec_ch][REG_TC_HI];
            default:     rbyte = 8'h00;
        endcase
        if (dec_dat_rd)
            rbyte = f_avail[dec_ch] ? f_head[dec_ch] : 8'h00;
        if (!(dec_cmd_rd || dec_dat_rd))
            rbyte = 8'h00;
        bus_rdata = dec_upper ? {rbyte, 8'h00} : {8'h00, rbyte};
    end

    always_comb begin
        st_d        = st_q;
        st_d.tx_vld = '0;

        mie     = st_q.wfile[0][REG_MASTER][BIT_MIE];
        rx_mode = |st_q.wfile[0][REG_IRQCFG][4:3];

        pend_set = 8'h00;
        for (int c = 0; c < NUM_CH; c++) begin
            if (mie && rx_mode && f_avail[c])
                pend_set[rx_pend_pos(c)] = 1'b1;
            if (dec_dat_wr && (dec_ch == 1'(c)) && mie && st_q.wfile[c][REG_IRQCFG][BIT_TXIE])
                pend_set[tx_pend_pos(c)] = 1'b1;
        end
        pend_clr  = dec_dat_rd ||
                    (dec_cmd_rd && (dec_ch == 1'b0) && (st_q.ptr[0] == REG_PENDING));
        st_d.pend = pend_clr ? 8'h00 : (st_q.pend | pend_set);

        if (dec_cmd_wr) begin
            if (!st_q.sel[dec_ch]) begin
                st_d.ptr[dec_ch] = dec_wbyte[3:0];
                st_d.sel[dec_ch] = 1'b1;
            end else begin
                st_d.wfile[dec_ch][st_q.ptr[dec_ch]] = dec_wbyte;
                st_d.ptr[dec_ch] = 4'd0;
                st_d.sel[dec_ch] = 1'b0;
            end
        end
        if (dec_cmd_rd) begin
            st_d.ptr[dec_ch] = 4'd0;
            st_d.sel[dec_ch] = 1'b0;
        end
        if (dec_dat_wr) begin
            st_d.tx_vld[dec_ch]  = 1'b1;
            st_d.tx_byte[dec_ch] = dec_wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.wfile[0][REG_MASTER][BIT_MIE] && (st_q.pend != 8'h00);

    AST_PTR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_cmd_wr && st_q.sel[dec_ch]) |=>
        (st_q.ptr[$past(dec_ch)] == 4'd0 && !st_q.sel[$past(dec_ch)])); // R2
    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_cmd_rd |=> !st_q.sel[$past(dec_ch)]); // R3
    AST_RX_PEND_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend[5]) |-> $past(f_cnt[0] != '0)); // R6
    AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid[1] |-> $past(dec_dat_wr && dec_ch == 1'b1)); // R8
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_dat_rd |=> (st_q.pend == 8'h00)); // R10
endmodule

// File: tb/dual_sio_regif_bench.sv
`timescale 1ns/100ps
module dual_sio_regif_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic [1:0]  rx_in_valid = '0;
    logic [15:0] rx_in_data = '0;
    logic [1:0]  tx_valid;
    logic [15:0] tx_data;
    logic        irq;

    int nchk = 0, nerr = 0, cycles = 0;
    logic [1:0]  txv_s;
    logic [15:0] txd_s;
    logic        irq_s;
    logic [7:0]  tc_model [2][2];
    logic [7:0]  q_model [$];

    always #2.5 clk = ~clk;

    dual_sio_regif #(.RX_DEPTH (DEPTH)) u_dual_sio_regif (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_write (bus_write),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .rx_in_valid (rx_in_valid), .rx_in_data (rx_in_data),
        .tx_valid (tx_valid), .tx_data (tx_data), .irq (irq)
    );

    function automatic logic [7:0] status_exp(input bit avail);
        return 8'h04 | {7'd0, avail};
    endfunction
    function automatic logic [3:0] cmd_a(input bit ch);
        return {ch, 3'd1};
    endfunction
    function automatic logic [3:0] dat_a(input bit ch);
        return {ch, 3'd5};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input logic [3:0] a, input logic [15:0] wd,
                       output logic [15:0] rd);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = wd;
        #1 rd = bus_rdata;
        @(posedge clk);
        #1;
        txv_s = tx_valid; txd_s = tx_data; irq_s = irq;
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic wreg(input bit ch, input logic [3:0] r, input logic [7:0] v);
        logic [15:0] d;
        acc(1'b1, cmd_a(ch), {12'd0, r}, d);
        acc(1'b1, cmd_a(ch), {8'd0, v}, d);
    endtask

    task automatic rreg(input bit ch, input logic [3:0] r, output logic [7:0] v);
        logic [15:0] d;
        acc(1'b1, cmd_a(ch), {12'd0, r}, d);
        acc(1'b0, cmd_a(ch), 16'd0, d);
        v = d[7:0];
    endtask

    task automatic line_push(input bit ch, input logic [7:0] b);
        @(negedge clk);
        rx_in_valid[ch] = 1'b1; rx_in_data[ch*8 +: 8] = b;
        @(posedge clk);
        #1 rx_in_valid = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1 irq_s = irq;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                nerr++; nchk++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("Result: errors=%0d of %0d checks", nerr, nchk);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] d;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        chk("R13 irq after reset", irq, 0);
        chk("R8 tx_valid after reset", tx_valid, 0);
        acc(1'b0, cmd_a(0), 16'd0, d);
        chk("R3/R4 status read without pointer", d, status_exp(0));
        rreg(1, 4'd1, v);  chk("R4 reg1 zero", v, 0);
        rreg(0, 4'd7, v);  chk("R4 unassigned reg zero", v, 0);

        // R12 shifted form
        acc(1'b1, 4'h0, 16'h0C00, d);
        acc(1'b1, 4'h0, 16'h3300, d);
        acc(1'b0, 4'h0, 16'h0000, d);
        chk("R12 shifted read of status", d, {status_exp(0), 8'h00});
        rreg(0, 4'd12, v); chk("R12 shifted write landed", v, 8'h33);
        acc(1'b1, 4'h4, 16'h4100, d);
        chk("R12 shifted data write tx", txd_s[7:0], 8'h41);
        chk("R8 tx strobe channel A", txv_s, 2'b01);
        tc_model[0][0] = 8'h33; tc_model[0][1] = 8'h00;
        tc_model[1][0] = 8'h00; tc_model[1][1] = 8'h00;

        // R2/R3 pointer sequencing
        wreg(0, 4'd13, 8'h5A);
        tc_model[0][1] = 8'h5A;
        rreg(0, 4'd13, v); chk("R2 second write stores", v, 8'h5A);
        rreg(0, 4'd12, v); chk("R2 other register untouched", v, 8'h33);
        acc(1'b1, cmd_a(0), 16'd12, d);
        acc(1'b0, cmd_a(0), 16'd0, d);
        chk("R3 read selected", d[7:0], 8'h33);
        acc(1'b0, cmd_a(0), 16'd0, d);
        chk("R3 pointer back to zero", d[7:0], status_exp(0));

        // R1 other offsets ignored
        acc(1'b1, cmd_a(0), 16'd13, d);
        acc(1'b1, 4'h2, 16'h00FF, d);
        acc(1'b0, 4'h3, 16'h0000, d);
        chk("R1 other offset reads zero", d, 0);
        acc(1'b0, cmd_a(0), 16'd0, d);
        chk("R1 selection kept across ignored access", d[7:0], 8'h5A);

        // R5 random time-constant readback
        for (int i = 0; i < 24; i++) begin
            bit ch; bit hi; logic [7:0] r;
            ch = 1'($urandom); hi = 1'($urandom); r = 8'($urandom);
            wreg(ch, hi ? 4'd13 : 4'd12, r);
            tc_model[ch][hi] = r;
            rreg(ch, hi ? 4'd13 : 4'd12, v);
            chk("R5 time constant readback", v, tc_model[ch][hi]);
        end

        // R10 empty read
        acc(1'b0, dat_a(0), 16'd0, d);
        chk("R10 empty data read", d, 0);

        // R14/R10 random FIFO traffic against a queue model
        for (int i = 0; i < 40; i++) begin
            if (($urandom % 2 == 0) && q_model.size() < DEPTH) begin
                logic [7:0] b;
                b = 8'($urandom);
                line_push(0, b);
                q_model.push_back(b);
            end else begin
                logic [7:0] e;
                e = (q_model.size() != 0) ? q_model.pop_front() : 8'h00;
                acc(1'b0, dat_a(0), 16'd0, d);
                chk("R10 fifo order", d, e);
            end
        end
        while (q_model.size() != 0) begin
            logic [7:0] e;
            e = q_model.pop_front();
            acc(1'b0, dat_a(0), 16'd0, d);
            chk("R10 drain", d, e);
        end
        for (int i = 0; i < DEPTH + 2; i++) line_push(0, 8'(8'h80 + i));
        rreg(0, 4'd0, v); chk("R4 status with data", v, status_exp(1));
        for (int i = 0; i < DEPTH; i++) begin
            acc(1'b0, dat_a(0), 16'd0, d);
            chk("R14 full keeps first bytes", d, 8'h80 + i);
        end
        acc(1'b0, dat_a(0), 16'd0, d);
        chk("R14 overflow bytes dropped", d, 0);

        // R9 loopback on channel B
        wreg(1, 4'd14, 8'h10);
        acc(1'b1, dat_a(1), 16'h0077, d);
        chk("R8 tx strobe channel B", txv_s, 2'b10);
        chk("R8 tx byte channel B", txd_s[15:8], 8'h77);
        rreg(1, 4'd0, v); chk("R9 loopback sets avail", v, status_exp(1));
        rreg(0, 4'd0, v); chk("R9 other channel untouched", v, status_exp(0));
        acc(1'b0, dat_a(1), 16'd0, d);
        chk("R9 loopback byte", d, 8'h77);

        // R6/R11/R13 receive pending
        wreg(0, 4'd9, 8'h08);
        wreg(0, 4'd1, 8'h10);
        line_push(1, 8'hA5);
        idle(1);
        chk("R13 irq on receive", irq_s, 1);
        rreg(1, 4'd3, v); chk("R11 channel B reg3 zero", v, 0);
        rreg(0, 4'd3, v); chk("R6 channel B rx pending bit", v, 8'h04);
        acc(1'b0, dat_a(1), 16'd0, d);
        chk("R10 pop received byte", d, 8'hA5);
        chk("R10 data read clears irq", irq_s, 0);
        idle(2);
        chk("R13 irq stays low", irq_s, 0);

        // R7/R11 transmit pending
        wreg(0, 4'd1, 8'h02);
        acc(1'b1, dat_a(0), 16'h0011, d);
        chk("R7 tx pending raises irq", irq_s, 1);
        rreg(1, 4'd3, v); chk("R11 channel B reg3 zero", v, 0);
        rreg(0, 4'd3, v); chk("R7 channel A tx bit kept then read", v, 8'h10);
        idle(1);
        chk("R11 read clears irq", irq_s, 0);
        rreg(0, 4'd3, v); chk("R11 pending cleared", v, 0);
        acc(1'b1, dat_a(1), 16'h0022, d);
        chk("R7 no tx pending without channel B enable", irq_s, 0);
        wreg(1, 4'd1, 8'h02);
        acc(1'b1, dat_a(1), 16'h0033, d);
        rreg(0, 4'd3, v); chk("R7 channel B tx bit", v, 8'h02);
        wreg(0, 4'd9, 8'h00);
        acc(1'b1, dat_a(0), 16'h0044, d);
        chk("R13 irq low without master enable", irq_s, 0);
        rreg(0, 4'd3, v); chk("R7 no pending without master enable", v, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule